// File: doc/BRIEF.md
# Memory Read Latency Calibrator

This block sits between an address generator and a pair of external memories, one holding twiddle factors and one holding data, that share one read latency. That latency is unknown at design time but stays fixed while a transform runs. After a start pulse the block counts the clock edges from the first address strobe to the first returned-data strobe. It keeps that count as the latency and raises a calibrated flag. Because both memories answer after the same number of cycles, one measurement covers both.

Every cycle the address side presents a tag, such as a pass index or an output address. The block delays each tag through a tapped shift register and reads it out at the tap chosen by the measured latency. Each tag then appears together with the twiddle and data word fetched for it, including on the very first returned word. If no data strobe comes back within the largest latency the block supports, it raises an error flag instead of calibrating.

Top module: `mem_lat_calib`

## Requirements
- R1: After reset, `calibrated` is 0, `error` is 0 and `latency` is 0.
- R2: After a start, the first cycle with `addr_valid` high is the reference cycle. If the first cycle with `data_valid` high comes L cycles later (L from 0 to DEPTH-1, where 0 means the same cycle), `latency` becomes L and `calibrated` is 1 from the following cycle.
- R3: `addr_valid` in the same cycle as the start pulse, and `data_valid` before the reference cycle, are ignored. They do not start or end the measurement.
- R4: If `data_valid` stays low for DEPTH-1 cycles after the reference cycle, `error` is 1 from the next cycle, `calibrated` stays 0 and `latency` stays 0.
- R5: Once `calibrated` is 1, further strobes leave `latency` and `calibrated` unchanged until the next start.
- R6: In every cycle with `data_valid` high during or after a successful measurement, `tag_out` equals the `tag_in` that was presented with `addr_valid` exactly `latency` cycles earlier. This holds from the first returned word onwards.
- R7: A start pulse clears `calibrated`, `error` and `latency` in the next cycle and begins a new measurement, even while a measurement is running.
- R8: `calibrated` and `error` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that re-arms the measurement |
| addr_valid | input | 1 | Address strobe from the address generator |
| tag_in | input | TAG_W | Tag that goes with the current address |
| data_valid | input | 1 | Returned twiddle/data strobe |
| latency | output | CW | Measured latency in cycles (CW = log2 DEPTH) |
| calibrated | output | 1 | Measurement completed successfully |
| tag_out | output | TAG_W | Tag aligned with the returned word |
| error | output | 1 | No data strobe within DEPTH-1 cycles |

## Verification
The bench builds the block with DEPTH = 16 and TAG_W = 10. With these values the latencies 0, 1, 5 and 15 can all be measured, so both ends of the 4-bit latency range are covered, and the timeout is checked on the exact cycle it fires. Tag streams are scored against a queue at each of these latencies. Restarts, strobes that must be ignored, and strobes that arrive after calibration each have their own scenario.

// File: rtl/mem_lat_calib.sv
module mem_lat_calib #(
  parameter int TAG_W = 10,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             addr_valid,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             data_valid,
  output logic [CW-1:0]    latency,
  output logic             calibrated,
  output logic [TAG_W-1:0] tag_out,
  output logic             error
);
  localparam logic [CW-1:0] MAXL = CW'(DEPTH - 1);

  logic          armed, meas;
  logic [CW-1:0] cnt, sel;
  logic [TAG_W-1:0] tap_q [1:DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; meas <= 1'b0; cnt <= '0;
      latency <= '0; calibrated <= 1'b0; error <= 1'b0;
    end else if (start) begin
      armed <= 1'b1; meas <= 1'b0; cnt <= '0;
      latency <= '0; calibrated <= 1'b0; error <= 1'b0;
    end else if (armed && addr_valid) begin
      armed <= 1'b0;
      cnt   <= CW'(1);
      if (data_valid) calibrated <= 1'b1;
      else            meas <= 1'b1;
    end else if (meas) begin
      if (data_valid) begin
        meas <= 1'b0; calibrated <= 1'b1; latency <= cnt;
      end else if (cnt == MAXL) begin
        meas <= 1'b0; error <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < DEPTH; k++) tap_q[k] <= '0;
    end else begin
      tap_q[1] <= tag_in;
      for (int k = 2; k < DEPTH; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  assign sel = meas ? cnt : latency;

  always_comb begin
    tag_out = tag_in;
    for (int k = 1; k < DEPTH; k++)
      if (sel == CW'(k)) tag_out = tap_q[k];
  end

  // R8
  cal_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(calibrated && error));
  // R2
  cal_needs_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calibrated) |-> $past(data_valid));
  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!calibrated && !error && latency == '0));
  // R5
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (calibrated && !start) |=> ($stable(latency) && calibrated));
  // R4
  err_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> ($past(meas) && !$past(data_valid)));
endmodule

// File: tb/tb_mem_lat_calib.sv
module tb_mem_lat_calib;
  localparam int TAG_W = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, addr_valid = 1'b0, data_valid = 1'b0;
  logic [TAG_W-1:0] tag_in = '0;
  logic [CW-1:0] latency;
  logic calibrated, error;
  logic [TAG_W-1:0] tag_out;

  int checks = 0, failures = 0;
  bit mon_en = 1'b0;
  logic [TAG_W-1:0] exp_q [$];

  always #2 clk = ~clk;

  mem_lat_calib #(.TAG_W(TAG_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_valid(addr_valid),
    .tag_in(tag_in), .data_valid(data_valid), .latency(latency),
    .calibrated(calibrated), .tag_out(tag_out), .error(error));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  // monitor: score each returned word against the queued tag (R6)
  always @(negedge clk) begin
    if (mon_en && rst_n && data_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R6 queue empty", int'(tag_out), -1);
      else begin
        logic [TAG_W-1:0] e;
        e = exp_q.pop_front();
        check(tag_out == e, "R6 tag align", int'(tag_out), int'(e));
      end
    end
  end

  // driver: stream n tags with a memory latency of lat
  task automatic stream(input int lat, input int n, input int seed);
    exp_q.delete();
    mon_en = 1'b1;
    pulse_start();
    for (int k = 0; k < n + lat; k++) begin
      addr_valid = (k < n);
      tag_in = TAG_W'(seed * 37 + k * 113);
      if (k < n) exp_q.push_back(tag_in);
      data_valid = (k >= lat);
      tick();
    end
    addr_valid = 1'b0; data_valid = 1'b0;
    @(negedge clk);
    mon_en = 1'b0;
    check(calibrated == 1'b1, "R2 calibrated", int'(calibrated), 1);
    check(int'(latency) == lat, "R2 latency", int'(latency), lat);
    check(error == 1'b0, "R8 no error", int'(error), 0);
    check(exp_q.size() == 0, "R6 all scored", exp_q.size(), 0);
  endtask

  initial begin
    #(4 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(calibrated == 0, "R1 calibrated", int'(calibrated), 0);
    check(error == 0, "R1 error", int'(error), 0);
    check(latency == 0, "R1 latency", int'(latency), 0);
    rst_n = 1'b1;
    tick();

    stream(0, 12, 1);
    stream(1, 20, 2);
    stream(5, 30, 3);
    stream(15, 25, 4);

    // R5: late strobes after calibration change nothing
    stream(5, 8, 5);
    addr_valid = 1'b1; tick(); addr_valid = 1'b0;
    repeat (2) tick();
    data_valid = 1'b1; tick(); data_valid = 1'b0;
    @(negedge clk);
    check(latency == 5, "R5 latency held", int'(latency), 5);
    check(calibrated == 1, "R5 calibrated held", int'(calibrated), 1);

    // R7: start clears state
    pulse_start();
    @(negedge clk);
    check(calibrated == 0, "R7 calibrated cleared", int'(calibrated), 0);
    check(latency == 0, "R7 latency cleared", int'(latency), 0);

    // R3: addr_valid with start and early data_valid are ignored
    start = 1'b1; addr_valid = 1'b1; tick();
    start = 1'b0; addr_valid = 1'b0; data_valid = 1'b1; tick();
    data_valid = 1'b0;
    @(negedge clk);
    check(calibrated == 0, "R3 early dv ignored", int'(calibrated), 0);
    addr_valid = 1'b1; tick(); addr_valid = 1'b0;
    repeat (2) tick();
    data_valid = 1'b1; tick(); data_valid = 1'b0;
    @(negedge clk);
    check(latency == 3, "R3 latency from real ref", int'(latency), 3);
    check(calibrated == 1, "R3 calibrated", int'(calibrated), 1);

    // R7: restart during a measurement
    pulse_start();
    addr_valid = 1'b1; tick(); addr_valid = 1'b0;
    repeat (3) tick();
    pulse_start();
    addr_valid = 1'b1; tick(); addr_valid = 1'b0;
    tick();
    data_valid = 1'b1; tick(); data_valid = 1'b0;
    @(negedge clk);
    check(latency == 2, "R7 restart latency", int'(latency), 2);

    // R4: timeout
    pulse_start();
    addr_valid = 1'b1; tick(); addr_valid = 1'b0;
    repeat (14) tick();
    @(negedge clk);
    check(error == 0, "R4 no error before limit", int'(error), 0);
    tick();
    @(negedge clk);
    check(error == 1, "R4 error at limit", int'(error), 1);
    check(calibrated == 0, "R4 not calibrated", int'(calibrated), 0);
    check(latency == 0, "R4 latency zero", int'(latency), 0);
    data_valid = 1'b1; tick(); data_valid = 1'b0;
    @(negedge clk);
    check(calibrated == 0, "R8 late dv after error", int'(calibrated), 0);

    // R7: start clears error
    pulse_start();
    @(negedge clk);
    check(error == 0, "R7 error cleared", int'(error), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule